// File: doc/BRIEF.md
# Half-Duplex Bus Transmit Turnaround Controller

This block decides when a node on a shared two-wire half-duplex serial bus may take the line. It holds one queued transmit byte until the bus has been quiet for a configured number of half-bit periods. Quiet is measured from the last receive event, which is either a received-frame strobe or a low level on the receive line. The required silence always includes one extra half-bit. That extra half-bit covers the far node, which is still finishing its stop bit after the local receiver has already reported the frame in the middle of that stop bit.

When the silence is satisfied, the block turns on the line driver one half-bit before the start bit so the transceiver has time to enable. It then shifts out one asynchronous frame and drops the driver enable at the edge that ends the last stop bit. A request that arrives while a frame is on the line is held until that frame ends and a full new silence has passed.

Timing derives from an oversampling tick, `OVS` pulses per bit. A half-bit is `OVS/2` of these pulses, so the half-bit offset is counted exactly.

Top module: `hdx_turnaround_ctl`

## Requirements
- R1: After reset, `drv_en` is 0, `tx_line` is 1, `busy` is 0 and `tx_done` is 0.
- R2: With a byte queued, `drv_en` rises `gap_halves+1` half-bits after the last receive event, or if the gap is already satisfied, at the next half-bit boundary; it never rises earlier. Here `gap_halves = max(gap_cfg, 2*(DATA_W+2))`, a half-bit is `OVS/2` `samp_tick` pulses, and the gap is counted from the clock edge that samples the event.
- R3: A `gap_cfg` value below one character time (`2*(DATA_W+2)` half-bits, which is 20 for 8 data bits) is treated as exactly one character time.
- R4: While no frame is on the line, a `rx_done` pulse or a sampled `rx_line` level of 0 restarts the silence count from zero.
- R5: The first half-bit with `drv_en` high carries `tx_line` = 1, before the start bit.
- R6: The frame on `tx_line` is one start bit of 0, then `DATA_W` data bits least significant first, then stop bits of 1. Each bit lasts two half-bits.
- R7: With `two_stop`=1 (sampled when the frame starts), the frame has two stop bits, otherwise one. `drv_en` falls exactly at the end of the last stop bit, after `3+2*DATA_W+2*stops` half-bits in total.
- R8: `tx_done` is a one-cycle pulse in the last clock cycle during which `drv_en` is high.
- R9: A request accepted while a frame is on the line is sent once that frame ends and a new silence of `gap_halves+1` half-bits has passed. Receive events during a frame are ignored.
- R10: A `tx_req` while a byte is already queued is ignored. The queued byte is sent unchanged and no extra frame follows.
- R11: `busy` is high while a byte is queued or `drv_en` is high, and low otherwise. `tx_line` is 1 whenever `drv_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_tick | input | 1 | Oversampling tick, OVS pulses per bit |
| tx_req | input | 1 | Queue `tx_data` for sending (one-cycle strobe) |
| tx_data | input | DATA_W | Byte to send |
| rx_done | input | 1 | Received-frame strobe from the local receiver |
| rx_line | input | 1 | Receive line level, idle high |
| gap_cfg | input | GAP_W | Minimum silence in half-bits |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| tx_line | output | 1 | Serial transmit data |
| drv_en | output | 1 | Line driver enable |
| busy | output | 1 | Byte queued or frame in progress |
| tx_done | output | 1 | Pulse in the last driven cycle |

## Verification
A silence counter that fails to restart, or that saturates early, shows up at the ports as a `drv_en` rise displaced by whole half-bits, usually many of them. That rise is the first place the error appears. A fault in the half-bit position counter shifts data bits, removes the lead half-bit or moves the release edge. Each of these is caught within the same frame by comparing `tx_line` and `drv_en` against the expected frame in every cycle. Faults in the queue flag appear as a missing frame, a duplicate frame or a replaced byte, and they also hold `busy` at the wrong level.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [1:0] {
    PH_LEAD  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } tx_phase_e;

  // half-bits in one frame: lead half + (start + data + stops) * 2
  function automatic int frame_halves(int data_w, logic two_stop);
    return 1 + 2 * (1 + data_w + (two_stop ? 2 : 1));
  endfunction

  // one character time (start + data + one stop) in half-bits
  function automatic int min_gap_halves(int data_w);
    return 2 * (data_w + 2);
  endfunction

  function automatic int eff_gap(int cfg, int data_w);
    return (cfg < min_gap_halves(data_w)) ? min_gap_halves(data_w) : cfg;
  endfunction

  function automatic tx_phase_e phase_of(int half, int data_w);
    int slot;
    if (half == 0) return PH_LEAD;
    slot = (half - 1) / 2;
    if (slot == 0) return PH_START;
    if (slot <= data_w) return PH_DATA;
    return PH_STOP;
  endfunction

endpackage

// File: rtl/hdx_half_timer.sv
module hdx_half_timer #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_tick,
  input  logic resync,
  output logic half_pulse
);
  localparam int SW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [SW-1:0] LAST = SW'(HALF - 1);

  logic [SW-1:0] sub;

  assign half_pulse = samp_tick && (sub == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= '0;
    end else if (resync) begin
      sub <= '0;
    end else if (samp_tick) begin
      sub <= (sub == LAST) ? '0 : sub + 1'b1;
    end
  end
endmodule

// File: rtl/hdx_gap_meter.sv
module hdx_gap_meter
  import hdx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 8,
  localparam int CNT_W = GAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_pulse,
  input  logic             clr,
  input  logic [GAP_W-1:0] gap_cfg,
  output logic [CNT_W-1:0] gap_cnt,
  output logic             gap_done
);
  logic [CNT_W-1:0] eff_lim;

  assign eff_lim  = CNT_W'(eff_gap(int'(gap_cfg), DATA_W));
  // this half-bit edge completes the required silence (limit plus one half)
  assign gap_done = half_pulse && (gap_cnt >= eff_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (clr) begin
      gap_cnt <= '0;
    end else if (half_pulse && (gap_cnt != '1)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hdx_frame_tx.sv
module hdx_frame_tx
  import hdx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_pulse,
  input  logic              launch,
  input  logic [DATA_W-1:0] data_in,
  input  logic              two_stop_in,
  output logic              line_o,
  output logic              drv_o,
  output logic              last_o
);
  localparam int MAXH = frame_halves(DATA_W, 1'b1);
  localparam int HW   = $clog2(MAXH + 1);
  localparam int IW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic              active;
  logic [HW-1:0]     half_idx;
  logic [DATA_W-1:0] data_q;
  logic              two_q;
  logic [HW-1:0]     last_idx;
  logic [IW-1:0]     bit_sel;
  int                dsel;

  assign last_idx = HW'(frame_halves(DATA_W, two_q) - 1);
  assign last_o   = active && half_pulse && (half_idx == last_idx);
  assign drv_o    = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      half_idx <= '0;
      data_q   <= '0;
      two_q    <= 1'b0;
    end else if (launch) begin
      active   <= 1'b1;
      half_idx <= '0;
      data_q   <= data_in;
      two_q    <= two_stop_in;
    end else if (last_o) begin
      active   <= 1'b0;
      half_idx <= '0;
    end else if (active && half_pulse) begin
      half_idx <= half_idx + 1'b1;
    end
  end

  always_comb begin
    dsel    = (int'(half_idx) - 3) / 2;
    bit_sel = dsel[IW-1:0];
    line_o  = 1'b1;
    if (active) begin
      unique case (phase_of(int'(half_idx), DATA_W))
        PH_LEAD:  line_o = 1'b1;
        PH_START: line_o = 1'b0;
        PH_DATA:  line_o = data_q[bit_sel];
        PH_STOP:  line_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/hdx_turnaround_ctl.sv
module hdx_turnaround_ctl
  import hdx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_tick,
  input  logic              tx_req,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_done,
  input  logic              rx_line,
  input  logic [GAP_W-1:0]  gap_cfg,
  input  logic              two_stop,
  output logic              tx_line,
  output logic              drv_en,
  output logic              busy,
  output logic              tx_done
);
  localparam int HALF  = OVS / 2;
  localparam int CNT_W = GAP_W + 1;

  // named internal events, visible to the bound checker
  logic             half_pulse;
  logic             idle_act;
  logic             gap_clr;
  logic             gap_done;
  logic             launch;
  logic [CNT_W-1:0] gap_cnt;
  logic             pend_valid;
  logic [DATA_W-1:0] pend_data;

  // receive activity only counts while this node is not driving
  assign idle_act = (rx_done || !rx_line) && !drv_en;
  assign gap_clr  = idle_act || tx_done;
  assign launch   = pend_valid && !drv_en && gap_done && !idle_act;
  assign busy     = pend_valid || drv_en;

  hdx_half_timer #(.HALF(HALF)) u_half (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_tick  (samp_tick),
    .resync     (idle_act),
    .half_pulse (half_pulse)
  );

  hdx_gap_meter #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_pulse (half_pulse),
    .clr        (gap_clr),
    .gap_cfg    (gap_cfg),
    .gap_cnt    (gap_cnt),
    .gap_done   (gap_done)
  );

  hdx_frame_tx #(.DATA_W(DATA_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_pulse  (half_pulse),
    .launch      (launch),
    .data_in     (pend_data),
    .two_stop_in (two_stop),
    .line_o      (tx_line),
    .drv_o       (drv_en),
    .last_o      (tx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_data  <= '0;
    end else if (launch) begin
      pend_valid <= 1'b0;
    end else if (tx_req && !pend_valid) begin
      pend_valid <= 1'b1;
      pend_data  <= tx_data;
    end
  end
endmodule

// File: rtl/hdx_turnaround_chk.sv
module hdx_turnaround_chk
  import hdx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 8,
  localparam int CNT_W = GAP_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drv_en,
  input logic             tx_line,
  input logic             busy,
  input logic             tx_done,
  input logic             idle_act,
  input logic             half_pulse,
  input logic [CNT_W-1:0] gap_cnt,
  input logic [GAP_W-1:0] gap_cfg
);
  logic [CNT_W-1:0] lim_c;
  assign lim_c = CNT_W'(eff_gap(int'(gap_cfg), DATA_W));

  AST_GAP_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> ($past(gap_cnt) >= $past(lim_c))); // R2
  AST_DRIVE_ON_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(half_pulse)); // R2
  AST_ACT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    idle_act |=> (gap_cnt == '0)); // R4
  AST_LEAD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> tx_line); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !drv_en); // R7
  AST_FALL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> $past(tx_done)); // R7
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> tx_line); // R11
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> busy); // R11
endmodule

bind hdx_turnaround_ctl hdx_turnaround_chk #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .drv_en     (drv_en),
  .tx_line    (tx_line),
  .busy       (busy),
  .tx_done    (tx_done),
  .idle_act   (idle_act),
  .half_pulse (half_pulse),
  .gap_cnt    (gap_cnt),
  .gap_cfg    (gap_cfg)
);

// File: tb/test_hdx_turnaround_ctl.sv
`timescale 1ns/1ps
module test_hdx_turnaround_ctl;
  localparam int HB  = 8;        // clocks per half-bit (OVS=16, tick every cycle)
  localparam int BIG = 1 << 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_tick = 1'b1;
  logic       tx_req = 1'b0;
  logic [7:0] tx_data = '0;
  logic       rx_done = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] gap_cfg = 8'd20;
  logic       two_stop = 1'b0;
  logic       tx_line, drv_en, busy, tx_done;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hdx_turnaround_ctl i_hdx_turnaround_ctl (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .tx_req(tx_req),
    .tx_data(tx_data), .rx_done(rx_done), .rx_line(rx_line),
    .gap_cfg(gap_cfg), .two_stop(two_stop), .tx_line(tx_line),
    .drv_en(drv_en), .busy(busy), .tx_done(tx_done)
  );

  function automatic int wait_halves(int cfg);
    return ((cfg < 20) ? 20 : cfg) + 1;
  endfunction

  function automatic int flen(logic two);
    return (two ? 23 : 21) * HB;
  endfunction

  function automatic logic exp_line(int o, logic [7:0] b);
    int h, s;
    h = o / HB;
    if (h == 0) return 1'b1;
    s = (h - 1) / 2;
    if (s == 0) return 1'b0;
    if (s <= 8) return b[s-1];
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison of one frame; k = cycle of request, busy expected after it
  task automatic watch(input int k, input int ls, input logic [7:0] b, input logic two,
                       input int pend_after, input string gl, output int bits_bad);
    int len, endc, o;
    int e_pre, e_post, e_lead, e_bits, e_done, e_idle, e_busy;
    logic ed, eb;
    len = flen(two); endc = ls + len + 1;
    e_pre = 0; e_post = 0; e_lead = 0; e_bits = 0; e_done = 0; e_idle = 0; e_busy = 0;
    while (cyc <= endc) begin
      o  = cyc - ls;
      ed = (o >= 0) && (o < len);
      eb = ((cyc > k) && (o < len)) || (cyc > pend_after);
      if (drv_en !== ed) begin
        if (o < 0) e_pre++; else e_post++;
      end
      if (ed && o < HB && tx_line !== 1'b1) e_lead++;
      if (ed && o >= HB && tx_line !== exp_line(o, b)) e_bits++;
      if (!ed && tx_line !== 1'b1) e_idle++;
      if (tx_done !== (o == len - 1)) e_done++;
      if (busy !== eb) e_busy++;
      @(negedge clk);
    end
    check(e_pre == 0, gl, "driver enable before/at start", e_pre, 0);
    check(e_post == 0, "R7", "driver enable span/release", e_post, 0);
    check(e_lead == 0, "R5", "lead half-bit level", e_lead, 0);
    check(e_bits == 0, "R6", "frame bit mismatches", e_bits, 0);
    check(e_done == 0, "R8", "done pulse mismatches", e_done, 0);
    check(e_idle == 0 && e_busy == 0, "R11", "idle level/busy mismatches", e_idle + e_busy, 0);
    bits_bad = e_bits;
  endtask

  task automatic run_basic(input int gcfg, input logic two, input logic [7:0] b);
    int k, ls, bb;
    string gl;
    @(negedge clk);
    k = cyc;
    gap_cfg = 8'(gcfg); two_stop = two; tx_data = b; tx_req = 1'b1; rx_done = 1'b1;
    ls = k + 1 + HB * wait_halves(gcfg);
    gl = (gcfg < 20) ? "R3" : "R2";
    fork
      begin @(negedge clk); tx_req = 1'b0; rx_done = 1'b0; end
      watch(k, ls, b, two, BIG, gl, bb);
    join
  endtask

  initial begin : watchdog
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int k, ls1, ls2, bb1, bb2, m, stray;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(drv_en === 1'b0, "R1", "drv_en", drv_en, 0);
    check(tx_line === 1'b1, "R1", "tx_line", tx_line, 1);
    check(busy === 1'b0, "R1", "busy", busy, 0);
    check(tx_done === 1'b0, "R1", "tx_done", tx_done, 0);

    // sweep: gaps below, at and above one character, both stop settings
    foreach (gap_cfg_list[i]) begin
      for (int t = 0; t < 2; t++) begin
        run_basic(gap_cfg_list[i], t[0], 8'(8'hA5 ^ (i * 37 + t * 91)));
      end
    end

    // R4: line low then a receive strobe during the wait both restart the silence
    @(negedge clk);
    k = cyc; gap_cfg = 8'd20; two_stop = 1'b0; tx_data = 8'h3C; tx_req = 1'b1; rx_line = 1'b0;
    fork
      begin
        @(negedge clk); tx_req = 1'b0;
        repeat (11) @(negedge clk); rx_line = 1'b1;
        repeat (60) @(negedge clk); rx_done = 1'b1;
        @(negedge clk); rx_done = 1'b0;
      end
      watch(k, k + 72 + 1 + HB * 21, 8'h3C, 1'b0, BIG, "R4", bb1);
    join

    // R2: request long after the silence, starts at the next half-bit boundary
    @(negedge clk);
    k = cyc; rx_done = 1'b1;
    @(negedge clk); rx_done = 1'b0;
    while (cyc < k + 400) @(negedge clk);
    m = (401 + HB - 1) / HB;
    if (m < 21) m = 21;
    tx_data = 8'h81; tx_req = 1'b1;
    fork
      begin @(negedge clk); tx_req = 1'b0; end
      watch(k + 400, k + 1 + HB * m, 8'h81, 1'b0, BIG, "R2", bb1);
    join

    // R9, R10: request during a frame, receive noise during a frame, request while queued
    @(negedge clk);
    k = cyc; gap_cfg = 8'd20; two_stop = 1'b0; tx_data = 8'h5A; tx_req = 1'b1; rx_done = 1'b1;
    ls1 = k + 1 + HB * 21;
    ls2 = ls1 + flen(1'b0) + HB * 21;
    fork
      begin
        @(negedge clk); rx_done = 1'b0; tx_req = 1'b0;
        @(negedge clk); @(negedge clk);
        tx_data = 8'hFF; tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        while (cyc < ls1 + 40) @(negedge clk);
        tx_data = 8'hC3; tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        while (cyc < ls1 + 60) @(negedge clk);
        rx_done = 1'b1;
        @(negedge clk); rx_done = 1'b0;
        while (cyc < ls1 + 70) @(negedge clk);
        rx_line = 1'b0;
        repeat (5) @(negedge clk); rx_line = 1'b1;
      end
      begin
        watch(k, ls1, 8'h5A, 1'b0, ls1 + 40, "R2", bb1);
        watch(cyc - 1, ls2, 8'hC3, 1'b0, BIG, "R9", bb2);
      end
    join
    check(bb1 == 0, "R10", "queued byte replaced (bit errors)", bb1, 0);
    check(bb2 == 0, "R9", "held byte bit errors", bb2, 0);
    stray = 0;
    repeat (400) begin
      if (drv_en !== 1'b0 || busy !== 1'b0) stray++;
      @(negedge clk);
    end
    check(stray == 0, "R10", "extra frame after ignored request", stray, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int gap_cfg_list [7] = '{0, 7, 19, 20, 21, 35, 70};

endmodule